// File: doc/BRIEF.md
# Locked OTP Register Bank Controller

This block is the byte-wide register file of a small authentication device. It sits behind a simple parallel bus. A 6-bit address selects a bank in bits [5:4] and an offset in bits [3:0]. Read and write strobes are separate, and read data comes out one cycle after the read strobe. There are three banks:

- Bank 0 holds one-time-programmable storage: a configuration byte, a trim byte and twelve secret bytes.
- Bank 1 holds the control and status registers.
- Bank 2 holds the secret selectors, a 32-bit challenge and an 8-bit response.

Each register applies its own access type. Bank-0 secret ranges can be locked, which blocks both reads and writes. Once any lock bit is set, a device reset permanently stops all programming of the OTP storage. The configuration byte also drives three things outside the bank: the decoded chip-select match, the one-hot bus-speed selection and the power-on defaults of two control bits.

There are two reset inputs. `por_n` stands in for the factory state of the OTP storage. `rst_n` is the ordinary device reset, and the OTP contents survive it.

Top module: `otp_regbank`

## Requirements
- R1: `addr_match` follows configuration bits [7:6] and `frame_cs`. With 00 it is high only when `frame_cs` is 0. With 11 it is high only when `frame_cs` is 1. With 01 or 10 it is always high.
- R2: `speed_sel` is one-hot and equals 1 shifted left by configuration bits [5:4], so 0001 selects 0.5x, 0010 selects 1x, 0100 selects 2x and 1000 selects 4x. It reads 0010 after power-on.
- R3: After `por_n` the configuration byte (bank 0, offset 0) reads 0x1C. Every `rst_n` loads `int_en` from configuration bit 3 and `auto_sleep` from bit 2. The control register (bank 1, offset 0) reads `int_en` in bit 6 and `auto_sleep` in bit 1, and writes set those same bits.
- R4: Configuration bit 1 locks bank-0 offsets 0x2 to 0x9, and bit 0 locks offsets 0xA to 0xD. A locked secret reads as zero and ignores writes. An unlocked secret reads back what was written.
- R5: `otp_wr_dis` rises only during a `rst_n` assertion that finds a lock bit set, and only `por_n` clears it. While it is high, writes to the configuration, trim and secret bytes have no effect. Before that reset, those writes are still accepted even with a lock bit set.
- R6: The trim byte (bank 0, offset 1) accepts a write only while `test_mode` is high. At any other time the write is ignored.
- R7: The status register (bank 1, offset 1) is read-only and reads {2'b00, violation, 1'b0, cfg[7:6], cfg[1:0]}. The violation bit is set by any access to a locked secret. It is cleared by reading the status register, after the read has returned it.
- R8: Control bit 0 is clear-on-write. Writing 1 to it produces a one-cycle `soft_rst` pulse, and it always reads as 0.
- R9: The challenge occupies bank-2 offsets 0x1 to 0x4, least significant byte at 0x1. It is readable and appears on `challenge`.
- R10: The response at bank-2 offset 0x5 is write-only. It reads as zero and appears on `response`.
- R11: The selector register at bank-2 offset 0x0 is read/write in bits [3:0], reads 0 in bits [7:4], and appears on `secret_sel`.
- R12: `rdata` updates on the clock edge that samples `rd_en` and holds otherwise. Unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low; sets the OTP factory state |
| rst_n | input | 1 | Device reset, active low, synchronous |
| test_mode | input | 1 | Enables trim-byte programming |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 6 | Bank in [5:4], offset in [3:0] |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered |
| frame_cs | input | 1 | Chip-select bit from the current frame |
| addr_match | output | 1 | Device should answer the frame |
| speed_sel | output | 4 | One-hot bus-speed selection |
| int_en | output | 1 | Interrupt enable control bit |
| auto_sleep | output | 1 | Auto-sleep control bit |
| soft_rst | output | 1 | One-cycle soft-reset pulse |
| otp_wr_dis | output | 1 | OTP programming permanently refused |
| secret_sel | output | 4 | Secret selectors |
| challenge | output | 32 | Challenge value |
| response | output | 8 | Response value |

## Verification
The assertions assume three things about the inputs: `por_n` is only ever low while `rst_n` is also low, the strobes are low during reset, and `rd_en` and `wr_en` are never high together. The stimulus changes inputs only at falling edges, and each access task raises exactly one strobe for one cycle. Resets are applied with both strobes low. Sweeps cover every address-match and speed code, every secret byte in both lock states, and the configuration byte before and after the programming cut-off.

// File: rtl/otp_regbank.sv
module otp_regbank #(
  parameter int          N_SEC       = 12,
  parameter logic [7:0]  CFG_DEFAULT = 8'h1C
) (
  input  logic        clk,
  input  logic        por_n,
  input  logic        rst_n,
  input  logic        test_mode,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [5:0]  addr,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  input  logic        frame_cs,
  output logic        addr_match,
  output logic [3:0]  speed_sel,
  output logic        int_en,
  output logic        auto_sleep,
  output logic        soft_rst,
  output logic        otp_wr_dis,
  output logic [3:0]  secret_sel,
  output logic [31:0] challenge,
  output logic [7:0]  response
);
  localparam logic [1:0] B_OTP = 2'd0, B_CTL = 2'd1, B_AUTH = 2'd2;
  localparam logic [3:0] SEC_LO = 4'd2, SEC_HI = 4'(2 + N_SEC - 1), SET12_HI = 4'd9;

  logic [7:0] cfg, trim, rd_val;
  logic [7:0] sec [N_SEC];
  logic       acc_flag;

  wire [1:0] bank     = addr[5:4];
  wire [3:0] off      = addr[3:0];
  wire       is_sec   = bank == B_OTP && off >= SEC_LO && off <= SEC_HI;
  wire       sec_lock = is_sec && ((off <= SET12_HI) ? cfg[1] : cfg[0]);
  wire [3:0] sidx     = off - SEC_LO;
  wire       otp_we   = wr_en && !otp_wr_dis && bank == B_OTP;
  wire       ctl_sel  = bank == B_CTL && off == 4'd0;
  wire       stat_sel = bank == B_CTL && off == 4'd1;

  always_ff @(posedge clk) begin
    if (!por_n) begin
      cfg  <= CFG_DEFAULT;
      trim <= '0;
      for (int i = 0; i < N_SEC; i++) sec[i] <= '0;
    end else begin
      if (otp_we && off == 4'd0) cfg <= wdata;
      if (otp_we && off == 4'd1 && test_mode) trim <= wdata;
      if (otp_we && is_sec && !sec_lock) sec[sidx] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!por_n) otp_wr_dis <= 1'b0;
    else if (!rst_n && cfg[1:0] != 2'b00) otp_wr_dis <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_en     <= cfg[3];
      auto_sleep <= cfg[2];
      soft_rst   <= 1'b0;
      acc_flag   <= 1'b0;
      secret_sel <= '0;
      challenge  <= '0;
      response   <= '0;
      rdata      <= '0;
    end else begin
      soft_rst <= wr_en && ctl_sel && wdata[0];
      if (wr_en && ctl_sel) begin
        int_en     <= wdata[6];
        auto_sleep <= wdata[1];
      end
      if (rd_en && stat_sel) acc_flag <= 1'b0;
      if ((rd_en || wr_en) && sec_lock) acc_flag <= 1'b1;
      if (wr_en && bank == B_AUTH) begin
        case (off)
          4'd0: secret_sel      <= wdata[3:0];
          4'd1: challenge[7:0]   <= wdata;
          4'd2: challenge[15:8]  <= wdata;
          4'd3: challenge[23:16] <= wdata;
          4'd4: challenge[31:24] <= wdata;
          4'd5: response        <= wdata;
          default: ;
        endcase
      end
      if (rd_en) rdata <= rd_val;
    end
  end

  always_comb begin
    rd_val = '0;
    case (bank)
      B_OTP: begin
        if (off == 4'd0) rd_val = cfg;
        else if (off == 4'd1) rd_val = trim;
        else if (is_sec && !sec_lock) rd_val = sec[sidx];
      end
      B_CTL: begin
        if (ctl_sel) rd_val = {1'b0, int_en, 4'b0, auto_sleep, 1'b0};
        else if (stat_sel) rd_val = {2'b00, acc_flag, 1'b0, cfg[7:6], cfg[1:0]};
      end
      B_AUTH: begin
        case (off)
          4'd0: rd_val = {4'b0, secret_sel};
          4'd1: rd_val = challenge[7:0];
          4'd2: rd_val = challenge[15:8];
          4'd3: rd_val = challenge[23:16];
          4'd4: rd_val = challenge[31:24];
          default: rd_val = '0;
        endcase
      end
      default: rd_val = '0;
    endcase
  end

  assign addr_match = (cfg[7:6] == 2'b00) ? !frame_cs :
                      (cfg[7:6] == 2'b11) ?  frame_cs : 1'b1;
  assign speed_sel  = 4'b0001 << cfg[5:4];

  // R4
  locked_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && sec_lock |=> rdata == 8'h00);

  // R5
  otp_cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    otp_wr_dis && wr_en && bank == B_OTP && off == 4'd0 |=> $stable(cfg));

  // R5
  otp_dis_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    1'b1 |=> $stable(otp_wr_dis));

  // R6
  trim_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !test_mode |=> $stable(trim));

  // R7
  violation_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && stat_sel |=> !acc_flag);

  // R8
  soft_rst_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> $past(wr_en && ctl_sel && wdata[0]));
endmodule

// File: tb/otp_regbank_bench.sv
module otp_regbank_bench;
  logic        clk = 0, por_n = 0, rst_n = 0, test_mode = 0, wr_en = 0, rd_en = 0, frame_cs = 0;
  logic [5:0]  addr = '0;
  logic [7:0]  wdata = '0, rdata, response;
  logic        addr_match, int_en, auto_sleep, soft_rst, otp_wr_dis;
  logic [3:0]  speed_sel, secret_sel;
  logic [31:0] challenge;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  otp_regbank u_otp_regbank (.clk, .por_n, .rst_n, .test_mode, .wr_en, .rd_en, .addr,
    .wdata, .rdata, .frame_cs, .addr_match, .speed_sel, .int_en, .auto_sleep,
    .soft_rst, .otp_wr_dis, .secret_sel, .challenge, .response);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic dev_reset();
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic exp_m;
    repeat (4) @(negedge clk);
    por_n = 1; rst_n = 1;
    @(negedge clk);
    check("R12 reset rdata", rdata, 0);
    rd(6'h00, d); check("R3 cfg default", d, 8'h1C);
    check("R2 default speed", speed_sel, 4'b0010);
    check("R3 int_en default", int_en, 1);
    check("R3 auto_sleep default", auto_sleep, 1);
    rd(6'h10, d); check("R3 ctrl read", d, 8'h42);
    check("R5 no disable yet", otp_wr_dis, 0);

    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < 4; s++) begin
        wr(6'h00, 8'((m << 6) | (s << 4) | 8'h0C));
        check("R2 speed one-hot", speed_sel, 32'(1 << s));
        for (int c = 0; c < 2; c++) begin
          frame_cs = c[0]; #1;
          exp_m = (m == 0) ? !c[0] : (m == 3) ? c[0] : 1'b1;
          check("R1 addr match", addr_match, exp_m);
        end
        rd(6'h11, d); check("R7 status fields", d, 32'(m << 2));
      end
    end
    wr(6'h00, 8'h1C);

    for (int i = 0; i < 12; i++) wr(6'(2 + i), 8'(8'hA0 + i));
    for (int i = 0; i < 12; i++) begin
      rd(6'(2 + i), d); check("R4 unlocked secret", d, 8'hA0 + i);
    end

    wr(6'h01, 8'h55); rd(6'h01, d); check("R6 trim ignored", d, 8'h00);
    test_mode = 1; wr(6'h01, 8'h37); test_mode = 0;
    rd(6'h01, d); check("R6 trim written", d, 8'h37);

    wr(6'h11, 8'hFF); rd(6'h11, d); check("R7 status read-only", d, 8'h00);

    wr(6'h10, 8'h01);
    check("R8 soft_rst pulse", soft_rst, 1);
    @(negedge clk); check("R8 soft_rst one cycle", soft_rst, 0);
    rd(6'h10, d); check("R8 ctrl bit0 reads 0", d, 8'h00);
    check("R3 int_en written", int_en, 0);
    wr(6'h10, 8'h43); rd(6'h10, d); check("R8 ctrl after write", d, 8'h42);

    wr(6'h20, 8'hFB); rd(6'h20, d); check("R11 select read", d, 8'h0B);
    check("R11 select out", secret_sel, 4'hB);
    for (int i = 0; i < 4; i++) wr(6'(6'h21 + i), 8'(8'h11 * (i + 1)));
    check("R9 challenge order", challenge, 32'h44332211);
    for (int i = 0; i < 4; i++) begin
      rd(6'(6'h21 + i), d); check("R9 challenge read", d, 8'h11 * (i + 1));
    end
    wr(6'h25, 8'h9C); rd(6'h25, d); check("R10 response reads 0", d, 8'h00);
    check("R10 response out", response, 8'h9C);
    rd(6'h0F, d); check("R12 unmapped bank0", d, 0);
    rd(6'h30, d); check("R12 unmapped bank3", d, 0);
    rd(6'h1F, d); check("R12 unmapped bank1", d, 0);

    wr(6'h00, 8'h1E);
    for (int i = 0; i < 12; i++) begin
      rd(6'(2 + i), d); check("R4 lock bit1 ranges", d, (i < 8) ? 0 : 8'hA0 + i);
    end
    rd(6'h11, d); check("R7 violation set", d, 8'h22);
    rd(6'h11, d); check("R7 violation cleared", d, 8'h02);
    wr(6'h02, 8'hEE);
    wr(6'h00, 8'h1C);
    rd(6'h02, d); check("R4 locked write ignored", d, 8'hA0);
    wr(6'h00, 8'h11);
    rd(6'h00, d); check("R5 write before reset", d, 8'h11);
    for (int i = 0; i < 12; i++) begin
      rd(6'(2 + i), d); check("R4 lock bit0 ranges", d, (i < 8) ? 8'hA0 + i : 0);
    end
    rd(6'h11, d); check("R7 violation lock0", d, 8'h21);

    dev_reset();
    @(negedge clk);
    check("R5 disable latched", otp_wr_dis, 1);
    check("R3 int_en from cfg", int_en, 0);
    check("R3 auto_sleep from cfg", auto_sleep, 0);
    check("R11 select reset", secret_sel, 0);
    wr(6'h00, 8'h1C); rd(6'h00, d); check("R5 cfg frozen", d, 8'h11);
    wr(6'h02, 8'h77); rd(6'h02, d); check("R5 secret frozen", d, 8'hA0);
    test_mode = 1; wr(6'h01, 8'h99); test_mode = 0;
    rd(6'h01, d); check("R5 trim frozen", d, 8'h37);
    wr(6'h20, 8'h05); rd(6'h20, d); check("R11 select after lock", d, 8'h05);
    dev_reset();
    @(negedge clk);
    check("R5 disable survives reset", otp_wr_dis, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule